// File: doc/BRIEF.md
# Weighted Threshold Pulse Element with Veto

This block is a clocked decision cell for single-bit pulse signals. On every clock period it looks at a set of one-bit inputs. It can first invert any chosen input. It then adds up a weight for each active excitatory input and compares the total with a threshold. It emits a one-period output pulse in the following period when the total reaches the threshold. An input marked as inhibitory carries no weight. When such an input is active it acts as an absolute veto: the output is 0 whatever the excitatory total is.

The input count, the weight of each input, the threshold, the inhibitory mask and the inversion mask are all fixed when the design is elaborated. A weight greater than 1 has the same effect as wiring one source to the element several times. Combining inversion with weights builds functions such as "fire when A is active, or when both B and C are idle".

The output register is written as a two-state machine:
- **ST_QUIET** drives the output low.
- **ST_FIRING** drives it high.
- The **arm** transition goes from ST_QUIET to ST_FIRING when the decision is true.
- The **release** transition goes from ST_FIRING to ST_QUIET when the decision is false.
- Otherwise each state holds.
- A synchronous reset forces ST_QUIET.

Top module: `thresh_pulse_elem`

## Requirements
- R1: While `rst` is high at a rising clock edge, the output after that edge is 0, whatever the inputs are.
- R2: The output in period n+1 is the decision made from the inputs sampled at the edge that ends period n; a change of the inputs never alters the output before the next rising edge.
- R3: When no veto is present, the output fires (1) exactly when the sum of the weights of the active excitatory inputs is greater than or equal to `THRESH`, and is 0 otherwise.
- R4: If any inhibitory input (a bit set in `INHIB_MASK`, bit i for `pulse_in[i]`) is active after inversion, the output is 0 regardless of the excitatory sum.
- R5: Bit i of `NEG_MASK` inverts `pulse_in[i]` before both the weighting and the veto, so a marked input counts as active when it is 0.
- R6: Input i contributes the unsigned weight held in `WEIGHTS[i*WW +: WW]`, which is the same as counting that source that many times; inhibitory inputs contribute nothing to the sum.
- R7: With the default `THRESH` of 1 and unit weights, a single active excitatory input is enough to fire the output.
- R8: The output is not latched: a pulse lasts exactly as long as the firing condition held one period earlier, and drops in the period after the condition goes away.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one period is one pulse slot |
| rst | input | 1 | Synchronous reset, active high |
| pulse_in | input | N_IN | One-bit pulse inputs, one bit per source |
| pulse_out | output | 1 | Registered standard pulse: the decision for the previous period |

## Verification
Two configurations are driven through all sixteen combinations of four inputs. The first uses unit weights, a threshold of 1 and one vetoing input, which separates a plain OR with a veto from any other gate. The second uses a double weight on A, inverted B and C, a threshold of 2 and one vetoing input. It realises "A, or neither B nor C", and only a correct inversion, correct weighting and a correct compare reproduce its truth table. Directed sequences then apply reset while the firing inputs are held, check the one-period latency just before and just after an edge, and show that a pulse drops as soon as its cause disappears.

// File: rtl/tpe_pkg.sv
package tpe_pkg;

    // Output register as a two-state machine
    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_FIRING = 1'b1
    } tpe_state_t;

    // Width needed to hold the largest possible weighted sum
    function automatic int sum_width(input int n_in, input int ww);
        return $clog2(n_in * ((1 << ww) - 1) + 1);
    endfunction

endpackage

// File: rtl/tpe_condition.sv
// Per-input optional inversion of the raw pulse inputs
module tpe_condition #(
    parameter int              N_IN     = 4,
    parameter logic [N_IN-1:0] NEG_MASK = '0
) (
    input  logic [N_IN-1:0] raw_in,
    output logic [N_IN-1:0] cond_out
);

    for (genvar i = 0; i < N_IN; i++) begin : g_cond
        if (NEG_MASK[i]) begin : g_inv
            assign cond_out[i] = ~raw_in[i];
        end else begin : g_pass
            assign cond_out[i] = raw_in[i];
        end
    end

endmodule

// File: rtl/tpe_tally.sv
// Weighted sum of the active excitatory inputs
module tpe_tally #(
    parameter int                 N_IN       = 4,
    parameter int                 WW         = 2,
    parameter logic [N_IN*WW-1:0] WEIGHTS    = '0,
    parameter logic [N_IN-1:0]    INHIB_MASK = '0,
    localparam int                SUM_W      = tpe_pkg::sum_width(N_IN, WW)
) (
    input  logic [N_IN-1:0]  cond_in,
    output logic [SUM_W-1:0] tally
);

    logic [WW-1:0] share [N_IN];

    for (genvar i = 0; i < N_IN; i++) begin : g_share
        if (INHIB_MASK[i]) begin : g_inhib
            assign share[i] = '0;
        end else begin : g_excite
            assign share[i] = cond_in[i] ? WEIGHTS[i*WW +: WW] : '0;
        end
    end

    always_comb begin
        tally = '0;
        for (int i = 0; i < N_IN; i++) begin
            tally = tally + SUM_W'(share[i]);
        end
    end

endmodule

// File: rtl/tpe_veto.sv
// Absolute inhibition: any active inhibitory input vetoes the output
module tpe_veto #(
    parameter int              N_IN       = 4,
    parameter logic [N_IN-1:0] INHIB_MASK = '0
) (
    input  logic [N_IN-1:0] cond_in,
    output logic            veto
);

    assign veto = |(cond_in & INHIB_MASK);

endmodule

// File: rtl/thresh_pulse_elem.sv
module thresh_pulse_elem
    import tpe_pkg::*;
#(
    parameter int                 N_IN       = 4,
    parameter int                 WW         = 2,
    parameter int                 THRESH     = 1,
    parameter logic [N_IN*WW-1:0] WEIGHTS    = {N_IN{WW'(1)}},
    parameter logic [N_IN-1:0]    INHIB_MASK = {1'b1, {(N_IN-1){1'b0}}},
    parameter logic [N_IN-1:0]    NEG_MASK   = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_IN-1:0] pulse_in,
    output logic            pulse_out
);

    localparam int               SUM_W = sum_width(N_IN, WW);
    localparam logic [SUM_W:0]   THR_V = (SUM_W+1)'(THRESH);

    logic [N_IN-1:0]  cond;
    logic [SUM_W-1:0] tally;
    logic             veto;
    logic             fire;
    tpe_state_t       state, state_nxt;

    tpe_condition #(.N_IN(N_IN), .NEG_MASK(NEG_MASK)) u_cond (
        .raw_in  (pulse_in),
        .cond_out(cond)
    );

    tpe_tally #(
        .N_IN(N_IN), .WW(WW), .WEIGHTS(WEIGHTS), .INHIB_MASK(INHIB_MASK)
    ) u_tally (
        .cond_in(cond),
        .tally  (tally)
    );

    tpe_veto #(.N_IN(N_IN), .INHIB_MASK(INHIB_MASK)) u_veto (
        .cond_in(cond),
        .veto   (veto)
    );

    assign fire = !veto && ({1'b0, tally} >= THR_V);

    // Next-state: arm / release
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_QUIET:  if (fire)  state_nxt = ST_FIRING;  // arm
            ST_FIRING: if (!fire) state_nxt = ST_QUIET;   // release
            default:              state_nxt = ST_QUIET;
        endcase
    end

    // State register with synchronous reset
    always_ff @(posedge clk) begin
        if (rst) state <= ST_QUIET;
        else     state <= state_nxt;
    end

    // Output process
    always_comb begin
        pulse_out = (state == ST_FIRING);
    end

    // Reset leaves the element quiet
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !pulse_out);

    // Sum at or above threshold without veto fires next period
    assert_reach_fires_R3: assert property (@(posedge clk) disable iff (rst)
        (!veto && ({1'b0, tally} >= THR_V)) |=> pulse_out);

    // Sum below threshold never fires next period
    assert_below_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, tally} < THR_V) |=> !pulse_out);

    // Active inhibitory input silences the next period
    assert_veto_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        veto |=> !pulse_out);

    // A pulse in this period had a cause in the previous one
    assert_pulse_has_cause_R8: assert property (@(posedge clk) disable iff (rst)
        pulse_out |-> $past(fire));

endmodule

// File: tb/test_thresh_pulse_elem.sv
module test_thresh_pulse_elem;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] ia  = '0;
    logic [3:0] ib  = '0;
    logic       oa, ob;

    int n_vec  = 0;
    int n_miss = 0;
    bit done   = 0;

    always #2 clk = ~clk;  // 250 MHz

    // Instance A: defaults (unit weights, threshold 1, bit 3 vetoes)
    thresh_pulse_elem i_thresh_pulse_elem (
        .clk(clk), .rst(rst), .pulse_in(ia), .pulse_out(oa)
    );

    // Instance B: bit0 = A weight 2, bit1 = B inverted, bit2 = C inverted, bit3 vetoes
    thresh_pulse_elem #(
        .N_IN(4), .WW(2), .THRESH(2),
        .WEIGHTS(8'b01_01_01_10), .INHIB_MASK(4'b1000), .NEG_MASK(4'b0110)
    ) i_thresh_pulse_elem_b (
        .clk(clk), .rst(rst), .pulse_in(ib), .pulse_out(ob)
    );

    // Behavioural reference
    function automatic bit model(input logic [3:0] v, input int w0, input int w1,
                                 input int w2, input int w3, input logic [3:0] inh,
                                 input logic [3:0] neg, input int thr);
        int sum;
        int w [4];
        logic [3:0] c;
        w[0] = w0; w[1] = w1; w[2] = w2; w[3] = w3;
        c = v ^ neg;
        sum = 0;
        for (int i = 0; i < 4; i++) begin
            if (c[i] && inh[i]) return 1'b0;
            if (c[i]) sum += w[i];
        end
        return sum >= thr;
    endfunction

    function automatic bit exp_a(input logic [3:0] v);
        return model(v, 1, 1, 1, 1, 4'b1000, 4'b0000, 1);
    endfunction

    function automatic bit exp_b(input logic [3:0] v);
        return model(v, 2, 1, 1, 1, 4'b1000, 4'b0110, 2);
    endfunction

    function automatic string tag_of(input logic [3:0] v, input logic [3:0] neg,
                                     input logic r);
        if (r) return "R1";
        if ((v ^ neg) & 4'b1000) return "R4";
        return "R3";
    endfunction

    task automatic check(input string tag, input string which,
                         input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_miss++;
            $display("FAIL %s inst %s: got %b expected %b", tag, which, act, exp);
        end
    endtask

    // Drive at negedge, check at the following negedge
    task automatic step(input logic [3:0] a, input logic [3:0] b, input logic r,
                        input string ta, input string tb);
        logic ea, eb;
        ia = a; ib = b; rst = r;
        ea = r ? 1'b0 : exp_a(a);
        eb = r ? 1'b0 : exp_b(b);
        @(posedge clk);
        @(negedge clk);
        check(ta, "A", oa, ea);
        check(tb, "B", ob, eb);
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state, with inputs that would otherwise fire
        for (int k = 0; k < 3; k++) step(4'b0001, 4'b0001, 1'b1, "R1", "R1");

        // Exhaustive sweep of both configurations (R3, R4, R5, R6)
        for (int v = 0; v < 16; v++) begin
            step(4'(v), 4'(v), 1'b0, tag_of(4'(v), 4'b0000, 1'b0),
                 tag_of(4'(v), 4'b0110, 1'b0));
        end

        // R7: single excitatory input fires with the default threshold
        step(4'b0100, 4'b0010, 1'b0, "R7", "R3");
        // R6: A alone (weight 2) reaches threshold 2 in instance B
        step(4'b0000, 4'b0011, 1'b0, "R3", "R6");
        // R5: B and C both idle fire through inversion
        step(4'b0000, 4'b0000, 1'b0, "R3", "R5");
        // R5: only C active (inverted to 0, B inverted to 1): sum 1, below threshold 2
        step(4'b0000, 4'b0100, 1'b0, "R3", "R5");

        // R2: the output holds until the next edge after inputs change
        step(4'b0000, 4'b0110, 1'b0, "R2", "R2");
        ia = 4'b0001; ib = 4'b0001;
        #1;
        check("R2", "A", oa, 1'b0);
        check("R2", "B", ob, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check("R2", "A", oa, 1'b1);
        check("R2", "B", ob, 1'b1);

        // R8: pulse drops when the cause goes away
        step(4'b0000, 4'b0110, 1'b0, "R8", "R8");
        step(4'b0000, 4'b0110, 1'b0, "R8", "R8");

        // R4: veto on top of a firing pattern
        step(4'b1111, 4'b1001, 1'b0, "R4", "R4");

        // R1: reset in the middle of firing
        step(4'b0011, 4'b0001, 1'b0, "R3", "R3");
        step(4'b0011, 4'b0001, 1'b1, "R1", "R1");
        step(4'b0011, 4'b0001, 1'b0, "R3", "R3");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_vec++;
            n_miss++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

endmodule